// File: doc/BRIEF.md
# SMBus Host Controller Register File

This block is the software-visible register set of an SMBus host controller. A processor reaches it over a byte-wide strobe bus with an 8-bit address. Through it, software claims the controller, loads the target address, command code and data bytes, and fills or drains a block buffer. It then writes a start bit and polls the status byte until the transaction ends.

The serial protocol itself runs in a separate engine. When a transaction is accepted, this block snapshots every field the engine needs and holds that snapshot steady for the whole transaction, so software can stage the next request without disturbing the running one. The engine reports completion with a result code. It can also return two data bytes, write or read the block buffer directly by index, and flag a CRC fault, an alert or a finished byte.

Top module: `smb_host_regs`

## Requirements
- R1: After reset, every register reads 0x00, the first status read included.
- R2: The command code (0x03), slave address (0x04, bit0 = 1 read / 0 write, bits 7:1 device address), data0 (0x05), data1 (0x06) and PEC byte (0x08) registers read back the last value written. Auxiliary control (0x0D) keeps bits 1:0 (bit0 append CRC, bit1 buffer enable) and reads 0 elsewhere.
- R3: Control (0x02) reads back bit0 interrupt enable, bit1 kill (driven live on `eng_kill`), bits 4:2 command type and bit7 PEC enable. Bits 5 and 6 always read 0.
- R4: A control write with bit6 set while status bit0 (busy) is 0 does three things at that clock edge. It sets busy, raises `eng_start` for exactly one cycle, and latches the command type, PEC enable, slave address, code, data0, data1, PEC byte and auxiliary control onto the engine outputs. Those outputs hold until the next accepted start.
- R5: While busy is 1, a control write with bit6 set produces no start pulse and leaves the latched engine outputs alone. Its other control fields are still stored.
- R6: `eng_done` clears busy. `eng_result` then sets one status bit: 0 sets bit1 (done), 1 sets bit2 (device error), 2 sets bit3 (bus error), 3 sets bit4 (failed).
- R7: Status bits 7:1 clear when written with 1 and are unchanged when written with 0. Bit0 ignores writes. `eng_alert` sets bit5 and `eng_byte_done` sets bit7.
- R8: Reading status (0x00) while bit6 is 0 returns bit6 = 0 and then sets it, so the next read returns 1. Writing 1 to bit6 releases it.
- R9: With auxiliary control bit1 set, each read or write of port 0x07 accesses the buffer entry at the pointer and then advances the pointer by one, wrapping from the last entry to 0. Any read of control (0x02) returns the pointer to 0.
- R10: With auxiliary control bit1 clear, port 0x07 writes are ignored, reads return 0 and the pointer does not move.
- R11: Auxiliary status (0x0C) bit0 is set by `eng_crc_err` and cleared by writing 1.
- R12: `eng_buf_we` writes buffer entry `eng_buf_idx`, and `eng_buf_rdata` shows that entry. `eng_dat_we` loads data0 and data1 from the engine.
- R13: Unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| eng_start | output | 1 | One-cycle transaction launch |
| eng_kill | output | 1 | Live kill request from control bit1 |
| eng_cmd_type | output | 3 | Latched command type |
| eng_pec_en | output | 1 | Latched PEC enable |
| eng_slave | output | 8 | Latched slave address and direction |
| eng_code | output | 8 | Latched command code |
| eng_data0 | output | 8 | Latched data0 |
| eng_data1 | output | 8 | Latched data1 |
| eng_pec_byte | output | 8 | Latched PEC byte |
| eng_append_crc | output | 1 | Latched append-CRC option |
| eng_buf_en | output | 1 | Latched buffer enable |
| eng_done | input | 1 | Transaction finished pulse |
| eng_result | input | 2 | Completion code, qualified by eng_done |
| eng_crc_err | input | 1 | CRC fault pulse |
| eng_byte_done | input | 1 | Byte finished pulse |
| eng_alert | input | 1 | Alert event pulse |
| eng_dat_we | input | 1 | Load data0 and data1 from the engine |
| eng_dat0_in | input | 8 | Engine data0 value |
| eng_dat1_in | input | 8 | Engine data1 value |
| eng_buf_we | input | 1 | Engine buffer write |
| eng_buf_idx | input | PTR_W | Engine buffer index |
| eng_buf_wdata | input | 8 | Engine buffer write data |
| eng_buf_rdata | output | 8 | Buffer entry at eng_buf_idx |

## Verification
The hardest situation to reach is a second start arriving while a transaction is in flight, combined with software rewriting the staged registers underneath. Only then can a wrong snapshot or a duplicate launch show on the engine outputs. Each randomized transaction therefore issues a start, immediately issues a conflicting start with a different command type, rewrites data0, and only then completes with a random result code and CRC flag. The buffer pointer wrap is reached by writing one byte more than the buffer depth and checking that entry 0 was overwritten.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
   // register offsets (decoded by software, so they are fixed)
   localparam int OFF_STS  = 'h00;
   localparam int OFF_CTL  = 'h02;
   localparam int OFF_CODE = 'h03;
   localparam int OFF_SLV  = 'h04;
   localparam int OFF_DAT0 = 'h05;
   localparam int OFF_DAT1 = 'h06;
   localparam int OFF_BLK  = 'h07;
   localparam int OFF_PEC  = 'h08;
   localparam int OFF_AUXS = 'h0C;
   localparam int OFF_AUXC = 'h0D;

   // status bit positions
   localparam int ST_BUSY   = 0;
   localparam int ST_DONE   = 1;
   localparam int ST_DEVERR = 2;
   localparam int ST_BUSERR = 3;
   localparam int ST_FAILED = 4;
   localparam int ST_ALERT  = 5;
   localparam int ST_INUSE  = 6;
   localparam int ST_BYTE   = 7;

   // control bit positions
   localparam int CT_GO = 6;

   typedef enum logic [1:0] {
      RES_OK     = 2'd0,
      RES_DEVERR = 2'd1,
      RES_BUSERR = 2'd2,
      RES_FAILED = 2'd3
   } smbh_result_e;

   typedef struct packed {
      logic       pec_en;
      logic [2:0] cmd_type;
      logic       kill;
      logic       irq_en;
   } smbh_ctl_t;

   typedef struct packed {
      logic [2:0] cmd_type;
      logic       pec_en;
      logic [7:0] slave;
      logic [7:0] code;
      logic [7:0] data0;
      logic [7:0] data1;
      logic [7:0] pec_byte;
      logic       append_crc;
      logic       buf_en;
   } smbh_launch_t;
endpackage

// File: rtl/smbh_status.sv
module smbh_status
   import smbh_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_hit,
   input  logic       wr_hit,
   input  logic [7:1] wmask,
   input  logic       start_acc,
   input  logic       done,
   input  logic [1:0] result,
   input  logic       alert,
   input  logic       byte_done,
   output logic [7:0] status
);
   logic [7:0] sts_q;
   logic [7:1] clr_v, set_v;

   always_comb begin
      clr_v = wr_hit ? wmask : '0;
      set_v = '0;
      if (done) begin
         case (smbh_result_e'(result))
            RES_OK:     set_v[ST_DONE]   = 1'b1;
            RES_DEVERR: set_v[ST_DEVERR] = 1'b1;
            RES_BUSERR: set_v[ST_BUSERR] = 1'b1;
            default:    set_v[ST_FAILED] = 1'b1;
         endcase
      end
      set_v[ST_ALERT] = alert;
      set_v[ST_BYTE]  = byte_done;
      set_v[ST_INUSE] = rd_hit & ~sts_q[ST_INUSE];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_q <= '0;
      end else begin
         sts_q[7:1] <= (sts_q[7:1] & ~clr_v) | set_v;
         if (start_acc)
            sts_q[ST_BUSY] <= 1'b1;
         else if (done)
            sts_q[ST_BUSY] <= 1'b0;
      end
   end

   assign status = sts_q;

   // R8
   inuse_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit && !sts_q[ST_INUSE] |=> sts_q[ST_INUSE]);
   // R6
   done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start_acc |=> !sts_q[ST_BUSY]);
   // R7
   w1c_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit && wmask[ST_DONE] && !done |=> !sts_q[ST_DONE]);
endmodule

// File: rtl/smbh_blkbuf.sv
module smbh_blkbuf #(
   parameter int DEPTH = 32,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             port_rd,
   input  logic             port_wr,
   input  logic [7:0]       port_wdata,
   input  logic             ptr_clr,
   output logic [7:0]       port_rdata,
   input  logic             eng_we,
   input  logic [PTR_W-1:0] eng_idx,
   input  logic [7:0]       eng_wdata,
   output logic [7:0]       eng_rdata
);
   logic [7:0]       mem [DEPTH];
   logic [PTR_W-1:0] ptr_q, ptr_nxt;
   logic             step;

   assign step = en & (port_rd | port_wr);

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_wrap_free
         assign ptr_nxt = ptr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign ptr_nxt = (int'(ptr_q) == DEPTH - 1) ? '0 : ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (ptr_clr)
         ptr_q <= '0;
      else if (step)
         ptr_q <= ptr_nxt;
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (!rst_n)
            mem[i] <= '0;
         else if (en && port_wr) begin
            if (int'(ptr_q) == i) mem[i] <= port_wdata;
         end else if (eng_we) begin
            if (int'(eng_idx) == i) mem[i] <= eng_wdata;
         end
      end
   end

   assign port_rdata = en ? mem[ptr_q] : '0;
   assign eng_rdata  = (int'(eng_idx) < DEPTH) ? mem[eng_idx] : '0;

   // R9
   ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_clr |=> ptr_q == '0);
   // R10
   disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en && !ptr_clr |=> $stable(ptr_q));
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
   import smbh_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BUF_DEPTH = 32,
   localparam int PTR_W = $clog2(BUF_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              eng_start,
   output logic              eng_kill,
   output logic [2:0]        eng_cmd_type,
   output logic              eng_pec_en,
   output logic [7:0]        eng_slave,
   output logic [7:0]        eng_code,
   output logic [7:0]        eng_data0,
   output logic [7:0]        eng_data1,
   output logic [7:0]        eng_pec_byte,
   output logic              eng_append_crc,
   output logic              eng_buf_en,
   input  logic              eng_done,
   input  logic [1:0]        eng_result,
   input  logic              eng_crc_err,
   input  logic              eng_byte_done,
   input  logic              eng_alert,
   input  logic              eng_dat_we,
   input  logic [7:0]        eng_dat0_in,
   input  logic [7:0]        eng_dat1_in,
   input  logic              eng_buf_we,
   input  logic [PTR_W-1:0]  eng_buf_idx,
   input  logic [7:0]        eng_buf_wdata,
   output logic [7:0]        eng_buf_rdata
);
   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("smb_host_regs: ADDR_W must cover offset 0x0D");
      end
      if (BUF_DEPTH < 2) begin : g_bad_depth
         $error("smb_host_regs: BUF_DEPTH must be at least 2");
      end
   endgenerate

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
      return a == ADDR_W'(off);
   endfunction

   smbh_ctl_t    ctl_q;
   smbh_launch_t launch_q;
   logic [7:0]   code_q, slv_q, dat0_q, dat1_q, pec_q;
   logic [1:0]   auxc_q;
   logic         crc_q;
   logic         start_q;
   logic [7:0]   status;
   logic [7:0]   blk_rdata;
   logic         busy, start_acc;
   logic         wr_ctl, rd_ctl, wr_sts, rd_sts;

   assign wr_ctl    = bus_wr & hit(bus_addr, OFF_CTL);
   assign rd_ctl    = bus_rd & hit(bus_addr, OFF_CTL);
   assign wr_sts    = bus_wr & hit(bus_addr, OFF_STS);
   assign rd_sts    = bus_rd & hit(bus_addr, OFF_STS);
   assign busy      = status[ST_BUSY];
   assign start_acc = wr_ctl & bus_wdata[CT_GO] & ~busy;

   smbh_status u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_hit    (rd_sts),
      .wr_hit    (wr_sts),
      .wmask     (bus_wdata[7:1]),
      .start_acc (start_acc),
      .done      (eng_done),
      .result    (eng_result),
      .alert     (eng_alert),
      .byte_done (eng_byte_done),
      .status    (status)
   );

   smbh_blkbuf #(.DEPTH(BUF_DEPTH)) u_blkbuf (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (auxc_q[1]),
      .port_rd    (bus_rd & hit(bus_addr, OFF_BLK)),
      .port_wr    (bus_wr & hit(bus_addr, OFF_BLK)),
      .port_wdata (bus_wdata),
      .ptr_clr    (rd_ctl),
      .port_rdata (blk_rdata),
      .eng_we     (eng_buf_we),
      .eng_idx    (eng_buf_idx),
      .eng_wdata  (eng_buf_wdata),
      .eng_rdata  (eng_buf_rdata)
   );

   // software-staged registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         code_q <= '0;
         slv_q  <= '0;
         dat0_q <= '0;
         dat1_q <= '0;
         pec_q  <= '0;
         auxc_q <= '0;
         crc_q  <= 1'b0;
      end else begin
         if (wr_ctl) begin
            ctl_q.irq_en   <= bus_wdata[0];
            ctl_q.kill     <= bus_wdata[1];
            ctl_q.cmd_type <= bus_wdata[4:2];
            ctl_q.pec_en   <= bus_wdata[7];
         end
         if (bus_wr && hit(bus_addr, OFF_CODE)) code_q <= bus_wdata;
         if (bus_wr && hit(bus_addr, OFF_SLV))  slv_q  <= bus_wdata;
         if (bus_wr && hit(bus_addr, OFF_PEC))  pec_q  <= bus_wdata;
         if (bus_wr && hit(bus_addr, OFF_AUXC)) auxc_q <= bus_wdata[1:0];
         if (bus_wr && hit(bus_addr, OFF_DAT0)) dat0_q <= bus_wdata;
         else if (eng_dat_we)                   dat0_q <= eng_dat0_in;
         if (bus_wr && hit(bus_addr, OFF_DAT1)) dat1_q <= bus_wdata;
         else if (eng_dat_we)                   dat1_q <= eng_dat1_in;
         if (eng_crc_err)
            crc_q <= 1'b1;
         else if (bus_wr && hit(bus_addr, OFF_AUXS) && bus_wdata[0])
            crc_q <= 1'b0;
      end
   end

   // launch snapshot
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         launch_q <= '0;
         start_q  <= 1'b0;
      end else begin
         start_q <= start_acc;
         if (start_acc) begin
            launch_q.cmd_type   <= bus_wdata[4:2];
            launch_q.pec_en     <= bus_wdata[7];
            launch_q.slave      <= slv_q;
            launch_q.code       <= code_q;
            launch_q.data0      <= dat0_q;
            launch_q.data1      <= dat1_q;
            launch_q.pec_byte   <= pec_q;
            launch_q.append_crc <= auxc_q[0];
            launch_q.buf_en     <= auxc_q[1];
         end
      end
   end

   assign eng_start      = start_q;
   assign eng_kill       = ctl_q.kill;
   assign eng_cmd_type   = launch_q.cmd_type;
   assign eng_pec_en     = launch_q.pec_en;
   assign eng_slave      = launch_q.slave;
   assign eng_code       = launch_q.code;
   assign eng_data0      = launch_q.data0;
   assign eng_data1      = launch_q.data1;
   assign eng_pec_byte   = launch_q.pec_byte;
   assign eng_append_crc = launch_q.append_crc;
   assign eng_buf_en     = launch_q.buf_en;

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (hit(bus_addr, OFF_STS))       bus_rdata = status;
         else if (hit(bus_addr, OFF_CTL))  bus_rdata = {ctl_q.pec_en, 2'b00, ctl_q.cmd_type, ctl_q.kill, ctl_q.irq_en};
         else if (hit(bus_addr, OFF_CODE)) bus_rdata = code_q;
         else if (hit(bus_addr, OFF_SLV))  bus_rdata = slv_q;
         else if (hit(bus_addr, OFF_DAT0)) bus_rdata = dat0_q;
         else if (hit(bus_addr, OFF_DAT1)) bus_rdata = dat1_q;
         else if (hit(bus_addr, OFF_BLK))  bus_rdata = blk_rdata;
         else if (hit(bus_addr, OFF_PEC))  bus_rdata = pec_q;
         else if (hit(bus_addr, OFF_AUXS)) bus_rdata = {7'd0, crc_q};
         else if (hit(bus_addr, OFF_AUXC)) bus_rdata = {6'd0, auxc_q};
      end
   end

   // R4
   start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> status[ST_BUSY]);
   // R4
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);
   // R4
   launch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_start |-> $stable(eng_cmd_type) && $stable(eng_data0) && $stable(eng_slave));
   // R5
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl && bus_wdata[CT_GO] && status[ST_BUSY] |=> !eng_start);
   // R11
   crc_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_crc_err |=> crc_q);
endmodule

// File: tb/smb_host_regs_bench.sv
`timescale 1ns/1ps
module smb_host_regs_bench;
   localparam int DEPTH = 32;
   localparam int PW = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]    bus_addr = '0, bus_wdata = '0, bus_rdata;
   logic          eng_start, eng_kill, eng_pec_en, eng_append_crc, eng_buf_en;
   logic [2:0]    eng_cmd_type;
   logic [7:0]    eng_slave, eng_code, eng_data0, eng_data1, eng_pec_byte, eng_buf_rdata;
   logic          eng_done = 1'b0, eng_crc_err = 1'b0, eng_byte_done = 1'b0, eng_alert = 1'b0;
   logic [1:0]    eng_result = '0;
   logic          eng_dat_we = 1'b0, eng_buf_we = 1'b0;
   logic [7:0]    eng_dat0_in = '0, eng_dat1_in = '0, eng_buf_wdata = '0;
   logic [PW-1:0] eng_buf_idx = '0;

   always #10 clk = ~clk;

   smb_host_regs u_smb_host_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_start(eng_start), .eng_kill(eng_kill), .eng_cmd_type(eng_cmd_type),
      .eng_pec_en(eng_pec_en), .eng_slave(eng_slave), .eng_code(eng_code),
      .eng_data0(eng_data0), .eng_data1(eng_data1), .eng_pec_byte(eng_pec_byte),
      .eng_append_crc(eng_append_crc), .eng_buf_en(eng_buf_en),
      .eng_done(eng_done), .eng_result(eng_result), .eng_crc_err(eng_crc_err),
      .eng_byte_done(eng_byte_done), .eng_alert(eng_alert),
      .eng_dat_we(eng_dat_we), .eng_dat0_in(eng_dat0_in), .eng_dat1_in(eng_dat1_in),
      .eng_buf_we(eng_buf_we), .eng_buf_idx(eng_buf_idx),
      .eng_buf_wdata(eng_buf_wdata), .eng_buf_rdata(eng_buf_rdata)
   );

   int n_vec = 0, n_bad = 0;
   bit finished = 1'b0;
   logic [7:0] m_sts = '0;
   logic       m_crc = 1'b0;
   logic [7:0] m_buf [DEPTH];
   int         m_ptr = 0;

   function automatic logic [7:0] exp_ctl(input logic [7:0] w);
      return w & 8'h9F;
   endfunction
   function automatic logic [7:0] exp_auxc(input logic [7:0] w);
      return w & 8'h03;
   endfunction
   function automatic logic [7:0] result_bit(input logic [1:0] r);
      return 8'h02 << r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #5 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rd_sts(input string tag);
      logic [7:0] v;
      rd(8'h00, v);
      chk(tag, v, m_sts);
      m_sts[6] = 1'b1;
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic finish_txn(input logic [1:0] r, input logic c);
      eng_done = 1'b1; eng_result = r; eng_crc_err = c;
      @(negedge clk);
      eng_done = 1'b0; eng_crc_err = 1'b0;
      m_sts[0] = 1'b0;
      m_sts = m_sts | result_bit(r);
      m_crc = m_crc | c;
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v, ct, ct2, old_d0, w;
      logic [7:0] s_code, s_slv, s_d0, s_d1, s_pec, s_aux;
      logic [1:0] res;
      logic       crc;
      void'($urandom(32'h1357_2468));
      for (int i = 0; i < DEPTH; i++) m_buf[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values
      foreach (v[i]) ;
      rd(8'h02, v); chk("R1 ctl", v, 8'h00);
      rd(8'h03, v); chk("R1 code", v, 8'h00);
      rd(8'h04, v); chk("R1 slave", v, 8'h00);
      rd(8'h05, v); chk("R1 data0", v, 8'h00);
      rd(8'h06, v); chk("R1 data1", v, 8'h00);
      rd(8'h08, v); chk("R1 pec", v, 8'h00);
      rd(8'h0C, v); chk("R1 auxs", v, 8'h00);
      rd(8'h0D, v); chk("R1 auxc", v, 8'h00);
      chk("R1 start", eng_start, 1'b0);
      rd_sts("R1 status");

      // R8: semaphore
      rd_sts("R8 second read claimed");
      wr(8'h00, 8'h40); m_sts[6] = 1'b0;
      rd_sts("R8 released");
      rd_sts("R8 reclaimed");

      // R13: unmapped
      wr(8'h0A, 8'h5A);
      rd(8'h0A, v); chk("R13 unmapped", v, 8'h00);
      rd(8'h01, v); chk("R13 unmapped 01", v, 8'h00);

      // R2, R3: random read/write
      for (int i = 0; i < 60; i++) begin
         int k;
         k = $urandom_range(0, 6);
         w = 8'($urandom);
         case (k)
            0: begin wr(8'h03, w); rd(8'h03, v); chk("R2 code", v, w); end
            1: begin wr(8'h04, w); rd(8'h04, v); chk("R2 slave", v, w); end
            2: begin wr(8'h05, w); rd(8'h05, v); chk("R2 data0", v, w); end
            3: begin wr(8'h06, w); rd(8'h06, v); chk("R2 data1", v, w); end
            4: begin wr(8'h08, w); rd(8'h08, v); chk("R2 pec", v, w); end
            5: begin wr(8'h0D, w); rd(8'h0D, v); chk("R2 auxc", v, exp_auxc(w)); end
            default: begin
               w[6] = 1'b0;
               wr(8'h02, w); rd(8'h02, v); chk("R3 ctl", v, exp_ctl(w));
               chk("R3 kill", eng_kill, w[1]);
            end
         endcase
      end
      wr(8'h02, 8'hFF);
      chk("R3 start while busy0 sets kill", eng_kill, 1'b1);
      m_sts[0] = 1'b1;
      finish_txn(2'd0, 1'b0);
      rd(8'h02, v); chk("R3 wo bits", v, 8'h9F);
      wr(8'h00, 8'hFE); m_sts[7:1] = '0;

      // R4, R5, R6, R11, R7: random transactions
      for (int t = 0; t < 24; t++) begin
         s_code = 8'($urandom); s_slv = 8'($urandom); s_d0 = 8'($urandom);
         s_d1 = 8'($urandom); s_pec = 8'($urandom); s_aux = 8'($urandom);
         wr(8'h03, s_code); wr(8'h04, s_slv); wr(8'h05, s_d0);
         wr(8'h06, s_d1); wr(8'h08, s_pec); wr(8'h0D, s_aux);
         ct = 8'($urandom) | 8'h40;
         wr(8'h02, ct);
         m_sts[0] = 1'b1;
         chk("R4 start pulse", eng_start, 1'b1);
         chk("R4 cmd type", eng_cmd_type, ct[4:2]);
         chk("R4 pec en", eng_pec_en, ct[7]);
         chk("R4 slave", eng_slave, s_slv);
         chk("R4 code", eng_code, s_code);
         chk("R4 data0", eng_data0, s_d0);
         chk("R4 data1", eng_data1, s_d1);
         chk("R4 pec byte", eng_pec_byte, s_pec);
         chk("R4 aux", {eng_buf_en, eng_append_crc}, s_aux[1:0]);
         tick();
         chk("R4 single cycle", eng_start, 1'b0);
         ct2 = (ct ^ 8'h9C) | 8'h40;
         wr(8'h02, ct2);
         chk("R5 no pulse", eng_start, 1'b0);
         chk("R5 cmd held", eng_cmd_type, ct[4:2]);
         rd(8'h02, v); chk("R5 ctl stored", v, exp_ctl(ct2));
         old_d0 = s_d0;
         wr(8'h05, ~old_d0);
         chk("R4 data0 held", eng_data0, old_d0);
         rd_sts("R6 busy");
         res = 2'($urandom); crc = 1'($urandom);
         finish_txn(res, crc);
         rd_sts("R6 result");
         rd(8'h0C, v); chk("R11 crc flag", v, {7'd0, m_crc});
         wr(8'h0C, 8'h01); m_crc = 1'b0;
         rd(8'h0C, v); chk("R11 crc clear", v, 8'h00);
         w = 8'($urandom);
         wr(8'h00, w); m_sts[7:1] = m_sts[7:1] & ~w[7:1];
         rd_sts("R7 w1c");
      end

      // R7: alert and byte done
      wr(8'h00, 8'hFE); m_sts[7:1] = '0;
      eng_alert = 1'b1; eng_byte_done = 1'b1; tick();
      eng_alert = 1'b0; eng_byte_done = 1'b0;
      m_sts = m_sts | 8'hA0;
      rd_sts("R7 events");
      wr(8'h00, 8'h21); m_sts[5] = 1'b0;
      rd_sts("R7 partial clear");

      // R9: buffer with wrap
      wr(8'h0D, 8'h02);
      rd(8'h02, v); m_ptr = 0;
      for (int i = 0; i < DEPTH + 1; i++) begin
         w = 8'($urandom);
         wr(8'h07, w); m_buf[m_ptr] = w; m_ptr = (m_ptr + 1) % DEPTH;
      end
      rd(8'h02, v); m_ptr = 0;
      for (int i = 0; i < DEPTH; i++) begin
         rd(8'h07, v); chk("R9 buffer readback", v, m_buf[i]);
      end
      rd(8'h07, v); chk("R9 wrapped to entry0", v, m_buf[0]);
      rd(8'h07, v); rd(8'h02, w);
      rd(8'h07, v); chk("R9 ctl read resets ptr", v, m_buf[0]);

      // R12: engine side of buffer and data regs
      for (int i = 0; i < 6; i++) begin
         int ix;
         ix = $urandom_range(0, DEPTH - 1);
         eng_buf_idx = PW'(ix); #1;
         chk("R12 engine read", eng_buf_rdata, m_buf[ix]);
      end
      eng_buf_we = 1'b1; eng_buf_idx = PW'(5); eng_buf_wdata = 8'hC3; tick();
      eng_buf_we = 1'b0; m_buf[5] = 8'hC3;
      rd(8'h02, v);
      for (int i = 0; i < 6; i++) begin
         rd(8'h07, v); chk("R12 engine write", v, m_buf[i]);
      end
      eng_dat_we = 1'b1; eng_dat0_in = 8'h3E; eng_dat1_in = 8'hE3; tick();
      eng_dat_we = 1'b0;
      rd(8'h05, v); chk("R12 data0 from engine", v, 8'h3E);
      rd(8'h06, v); chk("R12 data1 from engine", v, 8'hE3);

      // R10: buffer disabled
      wr(8'h0D, 8'h00);
      rd(8'h02, v);
      wr(8'h07, 8'h11); wr(8'h07, 8'h22); wr(8'h07, 8'h33);
      rd(8'h07, v); chk("R10 disabled read", v, 8'h00);
      wr(8'h0D, 8'h02);
      rd(8'h07, v); chk("R10 entry0 untouched", v, m_buf[0]);
      rd(8'h07, v); chk("R10 pointer did not move", v, m_buf[1]);

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule